// File: doc/BRIEF.md
# Selectable-Ratio Controller Clock Generator

This block derives a controller clock from a faster source clock. A 3-bit ratio code picks one of eight divide ratios, two of which (6 and 24) are not powers of two. The code is captured only while a dedicated divider reset is held. The count restarts when that reset is released, so a new ratio always begins from a clean phase.

An enable gates the controller clock output. A bypass select replaces the divided clock with an external clock through a plain multiplexer, with no glitch protection. Beside the clock, the block produces a one-source-cycle strobe that marks each rising edge of the divided clock, so that logic running on the source clock can act in step with it. The captured ratio code and the enable are read back so that software can confirm its settings took hold.

A synchronous, active-high block reset clears every register.

Top module: `ctlclk_gen`

## Requirements
- R1: The captured ratio code maps to these divide ratios: 0 gives 1, 1 gives 2, 2 gives 4, 3 gives 6, 4 gives 8, 5 gives 16, 6 gives 24 and 7 gives 32. The divided clock repeats every that many source cycles.
- R2: While `div_rst` is sampled high, the ratio code is captured and shows on `ratio_rb` after that edge. During this time the divided clock is held low and `ctl_tick` is low.
- R3: Count the source edges that sample `div_rst` low, starting at 1. With a ratio N of 2 or more, the first rising edge of the divided clock comes at edge N. The clock is then high for N/2 source cycles and low for N/2 cycles.
- R4: A change on `ratio_sel` while `div_rst` is low is ignored until the next divider reset. Both `ratio_rb` and the output period keep the captured value.
- R5: When `clk_en` was sampled low at the last source edge, `ctl_clk` and `ctl_tick` are low. `en_rb` shows the sampled enable.
- R6: `ctl_tick` is high for exactly the source cycle that follows each rising edge of the divided clock. It is high only when enabled and not bypassed. With ratio 1 it is high in every cycle after release.
- R7: When `byp_sel` was sampled 1 at the last source edge, `ctl_clk` follows `byp_clk` (gated by the enable) and `ctl_tick` is low. When the sampled value is 0, the source-derived clock is used.
- R8: With ratio 1, once the first edge after release has been taken, `ctl_clk` is the source clock itself.
- R9: A synchronous `rst` clears the captured ratio code to 0, clears the enable, the bypass select and the divide state, and drives `ctl_clk` and `ctl_tick` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast source clock |
| rst | input | 1 | Synchronous active-high block reset |
| byp_clk | input | 1 | External clock used in bypass |
| ratio_sel | input | 3 | Ratio code, captured during divider reset |
| clk_en | input | 1 | Controller clock enable |
| byp_sel | input | 1 | 0: divided source clock, 1: external clock |
| div_rst | input | 1 | Divider reset, holds the count and captures the ratio |
| ctl_clk | output | 1 | Gated controller clock |
| ctl_tick | output | 1 | One-cycle strobe at each divided-clock rising edge |
| ratio_rb | output | 3 | Captured ratio code |
| en_rb | output | 1 | Sampled enable |

## Verification
The assertions check the following on every cycle:
- the count stays inside the captured ratio;
- the captured code holds steady outside the divider reset;
- the divided clock is low right after a divider reset;
- each rise of the divided clock lands on a count wrap;
- the strobe never lasts two cycles at ratios above 1;
- a disabled output stays low.

The exact cycle of the first rising edge, the 50% duty at each ratio, the pass-through at ratio 1, the bypass routing and the mapping from code to ratio can only be shown by the bench scenarios. The bench compares the output cycle by cycle against a count model.

// File: rtl/ctlclk_pkg.sv
package ctlclk_pkg;

    localparam int SEL_W     = 3;
    localparam int MAX_RATIO = 32;
    localparam int CNT_W     = $clog2(MAX_RATIO);

    typedef logic [SEL_W-1:0] ratio_code_t;
    typedef logic [CNT_W-1:0] div_cnt_t;

    typedef enum logic {
        SRC_DIVIDED = 1'b0,
        SRC_BYPASS  = 1'b1
    } clk_src_e;

    typedef struct packed {
        logic     en;
        clk_src_e src;
    } gate_cfg_t;

    // Last count value of a period (ratio minus one).
    function automatic div_cnt_t ratio_last(input ratio_code_t code);
        case (code)
            3'd0:    ratio_last = div_cnt_t'(0);
            3'd1:    ratio_last = div_cnt_t'(1);
            3'd2:    ratio_last = div_cnt_t'(3);
            3'd3:    ratio_last = div_cnt_t'(5);
            3'd4:    ratio_last = div_cnt_t'(7);
            3'd5:    ratio_last = div_cnt_t'(15);
            3'd6:    ratio_last = div_cnt_t'(23);
            default: ratio_last = div_cnt_t'(31);
        endcase
    endfunction

    // Number of high cycles per period; zero for the unity ratio.
    function automatic div_cnt_t ratio_half(input ratio_code_t code);
        div_cnt_t last;
        last = ratio_last(code);
        ratio_half = (last == '0) ? '0 : div_cnt_t'((32'(last) + 1) / 2);
    endfunction

endpackage

// File: rtl/ctlclk_cfg_reg.sv
module ctlclk_cfg_reg
    import ctlclk_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      en_in,
    input  logic      byp_in,
    output gate_cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en  <= 1'b0;
            cfg_q.src <= SRC_DIVIDED;
        end else begin
            cfg_q.en  <= en_in;
            cfg_q.src <= byp_in ? SRC_BYPASS : SRC_DIVIDED;
        end
    end

endmodule

// File: rtl/ctlclk_div_core.sv
module ctlclk_div_core
    import ctlclk_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        div_rst,
    input  ratio_code_t sel_in,
    input  logic        en_in,
    input  logic        byp_in,
    output ratio_code_t code_q,
    output logic        div_q,
    output logic        armed_q,
    output logic        tick_q
);

    div_cnt_t cnt_q;
    div_cnt_t cnt_nx;
    div_cnt_t last;
    div_cnt_t half;
    logic     wrap;

    always_comb begin
        last   = ratio_last(code_q);
        half   = ratio_half(code_q);
        wrap   = (cnt_q == last);
        cnt_nx = wrap ? '0 : cnt_q + div_cnt_t'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            cnt_q   <= '0;
            div_q   <= 1'b0;
            armed_q <= 1'b0;
            tick_q  <= 1'b0;
        end else if (div_rst) begin
            code_q  <= sel_in;
            cnt_q   <= '0;
            div_q   <= 1'b0;
            armed_q <= 1'b0;
            tick_q  <= 1'b0;
        end else begin
            cnt_q   <= cnt_nx;
            armed_q <= armed_q | wrap;
            div_q   <= (armed_q | wrap) && (cnt_nx < half);
            tick_q  <= wrap && en_in && !byp_in;
        end
    end

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= ratio_last(code_q)); // R1

    AST_RST_HOLDS_LOW: assert property (@(posedge clk) disable iff (rst)
        div_rst |=> (!div_q && !armed_q && !tick_q)); // R2

    AST_CODE_HELD: assert property (@(posedge clk) disable iff (rst)
        !div_rst |=> $stable(code_q)); // R4

    AST_RISE_ON_WRAP: assert property (@(posedge clk) disable iff (rst)
        $rose(div_q) |-> (cnt_q == '0)); // R3

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        (tick_q && code_q != '0 && !div_rst) |=> !tick_q); // R6

endmodule

// File: rtl/ctlclk_out_mux.sv
module ctlclk_out_mux
    import ctlclk_pkg::*;
(
    input  logic      src_clk,
    input  logic      byp_clk,
    input  logic      unity,
    input  logic      armed,
    input  logic      div_clk,
    input  gate_cfg_t cfg,
    output logic      clk_out
);

    logic base_clk;
    logic sel_clk;

    always_comb begin
        base_clk = unity ? (src_clk & armed) : div_clk;
        sel_clk  = (cfg.src == SRC_BYPASS) ? byp_clk : base_clk;
        clk_out  = cfg.en & sel_clk;
    end

endmodule

// File: rtl/ctlclk_gen.sv
module ctlclk_gen
    import ctlclk_pkg::*;
(
    input  logic       src_clk,
    input  logic       rst,
    input  logic       byp_clk,
    input  logic [2:0] ratio_sel,
    input  logic       clk_en,
    input  logic       byp_sel,
    input  logic       div_rst,
    output logic       ctl_clk,
    output logic       ctl_tick,
    output logic [2:0] ratio_rb,
    output logic       en_rb
);

    gate_cfg_t   cfg_q;
    ratio_code_t code_q;
    logic        div_q;
    logic        armed_q;
    logic        tick_q;

    ctlclk_cfg_reg u_cfg (
        .clk    (src_clk),
        .rst    (rst),
        .en_in  (clk_en),
        .byp_in (byp_sel),
        .cfg_q  (cfg_q)
    );

    ctlclk_div_core u_core (
        .clk     (src_clk),
        .rst     (rst),
        .div_rst (div_rst),
        .sel_in  (ratio_sel),
        .en_in   (clk_en),
        .byp_in  (byp_sel),
        .code_q  (code_q),
        .div_q   (div_q),
        .armed_q (armed_q),
        .tick_q  (tick_q)
    );

    ctlclk_out_mux u_mux (
        .src_clk (src_clk),
        .byp_clk (byp_clk),
        .unity   (code_q == '0),
        .armed   (armed_q),
        .div_clk (div_q),
        .cfg     (cfg_q),
        .clk_out (ctl_clk)
    );

    assign ctl_tick = tick_q;
    assign ratio_rb = code_q;
    assign en_rb    = cfg_q.en;

    AST_DISABLED_IDLE: assert property (@(posedge src_clk) disable iff (rst)
        !en_rb |-> (!ctl_clk && !ctl_tick)); // R5

    AST_BYPASS_NO_TICK: assert property (@(posedge src_clk) disable iff (rst)
        (cfg_q.src == SRC_BYPASS) |-> !ctl_tick); // R7

endmodule

// File: tb/ctlclk_gen_bench.sv
module ctlclk_gen_bench;

    localparam int CLK_PERIOD = 10;

    logic       src_clk = 1'b0;
    logic       rst = 1'b1;
    logic       byp_clk = 1'b0;
    logic [2:0] ratio_sel = 3'd0;
    logic       clk_en = 1'b0;
    logic       byp_sel = 1'b0;
    logic       div_rst = 1'b0;
    logic       ctl_clk;
    logic       ctl_tick;
    logic [2:0] ratio_rb;
    logic       en_rb;

    int checks = 0;
    int fails  = 0;

    ctlclk_gen u_ctlclk_gen (
        .src_clk   (src_clk),
        .rst       (rst),
        .byp_clk   (byp_clk),
        .ratio_sel (ratio_sel),
        .clk_en    (clk_en),
        .byp_sel   (byp_sel),
        .div_rst   (div_rst),
        .ctl_clk   (ctl_clk),
        .ctl_tick  (ctl_tick),
        .ratio_rb  (ratio_rb),
        .en_rb     (en_rb)
    );

    always #(CLK_PERIOD/2) src_clk = ~src_clk;

    function automatic int ratio_of(input int code);
        case (code)
            0: ratio_of = 1;
            1: ratio_of = 2;
            2: ratio_of = 4;
            3: ratio_of = 6;
            4: ratio_of = 8;
            5: ratio_of = 16;
            6: ratio_of = 24;
            default: ratio_of = 32;
        endcase
    endfunction

    // c = source edges since release; sample taken in the high phase of src_clk.
    function automatic bit exp_clk(input int n, input int c, input bit en);
        if (!en) return 1'b0;
        if (n == 1) return (c >= 1);
        if (c < n) return 1'b0;
        return ((c - n) % n) < (n / 2);
    endfunction

    function automatic bit exp_tick(input int n, input int c, input bit en);
        if (!en) return 1'b0;
        if (n == 1) return (c >= 1);
        if (c < n) return 1'b0;
        return ((c - n) % n) == 0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, expv, $time);
        end
    endtask

    task automatic step();
        @(posedge src_clk);
        #(CLK_PERIOD/4);
    endtask

    task automatic run_ratio(input int code, input int cycles, input bit en, input bit change_mid);
        int n;
        n = ratio_of(code);
        div_rst   = 1'b1;
        ratio_sel = 3'(code);
        clk_en    = en;
        byp_sel   = 1'b0;
        step();
        chk(ctl_clk == 1'b0, "R2 clk low in divider reset", int'(ctl_clk), 0);
        chk(ctl_tick == 1'b0, "R2 tick low in divider reset", int'(ctl_tick), 0);
        chk(int'(ratio_rb) == code, "R2 code captured", int'(ratio_rb), code);
        chk(en_rb == en, "R5 enable readback", int'(en_rb), int'(en));
        div_rst = 1'b0;
        for (int c = 1; c <= cycles; c++) begin
            step();
            chk(ctl_clk == exp_clk(n, c, en),
                (n == 1) ? "R8 unity pass-through" : "R3 R1 divided waveform",
                int'(ctl_clk), int'(exp_clk(n, c, en)));
            chk(ctl_tick == exp_tick(n, c, en), "R6 tick strobe",
                int'(ctl_tick), int'(exp_tick(n, c, en)));
            if (change_mid && c == 2) ratio_sel = 3'((code + 3) % 8);
        end
        chk(int'(ratio_rb) == code, "R4 code unchanged after live select change",
            int'(ratio_rb), code);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int code;
        void'($urandom(32'd2024));
        rst = 1'b1;
        step();
        step();
        chk(ctl_clk == 1'b0, "R9 reset clock low", int'(ctl_clk), 0);
        chk(ctl_tick == 1'b0, "R9 reset tick low", int'(ctl_tick), 0);
        chk(ratio_rb == 3'd0, "R9 reset code zero", int'(ratio_rb), 0);
        chk(en_rb == 1'b0, "R9 reset enable low", int'(en_rb), 0);
        rst = 1'b0;

        // Directed: every code once, with full periods checked.
        for (int k = 0; k < 8; k++) run_ratio(k, 2 * ratio_of(k) + 3, 1'b1, 1'b0);
        // Non-power-of-two codes with a live select change (R4).
        run_ratio(3, 26, 1'b1, 1'b1);
        run_ratio(6, 74, 1'b1, 1'b1);
        // Disabled output (R5).
        run_ratio(2, 12, 1'b0, 1'b0);
        chk(en_rb == 1'b0, "R5 enable readback low", int'(en_rb), 0);

        // Bypass routing (R7).
        run_ratio(2, 3, 1'b1, 1'b0);
        byp_sel = 1'b1;
        step();
        for (int j = 0; j < 4; j++) begin
            byp_clk = 1'b1;
            #1;
            chk(ctl_clk == 1'b1, "R7 bypass follows high", int'(ctl_clk), 1);
            byp_clk = 1'b0;
            #1;
            chk(ctl_clk == 1'b0, "R7 bypass follows low", int'(ctl_clk), 0);
            step();
            chk(ctl_tick == 1'b0, "R7 no tick in bypass", int'(ctl_tick), 0);
        end
        clk_en = 1'b0;
        step();
        byp_clk = 1'b1;
        #1;
        chk(ctl_clk == 1'b0, "R5 disabled bypass stays low", int'(ctl_clk), 0);
        byp_clk = 1'b0;
        byp_sel = 1'b0;

        // Random codes with random live select changes.
        for (int r = 0; r < 20; r++) begin
            code = int'($urandom % 8);
            run_ratio(code, 2 * ratio_of(code) + 2, 1'b1, 1'($urandom % 2));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule